// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the 32 data words of a fixed-point geometry coprocessor. The host processor reaches it through one write port and one combinational read port, each addressed by a 5-bit index. Most indices store the written word as given. Some indices reshape the value on the way in by sign- or zero-extending its low half. Others have side effects: a push slot feeds the screen-point FIFO, a packed 5:5:5 colour slot converts to and from the three intermediate channel registers, and a source slot drives a leading-sign-bit counter.

The arithmetic engine beside the block uses three internal push ports. One feeds the screen-point FIFO (entries 12 to 14). One feeds the depth FIFO (entries 16 to 19). One feeds the colour FIFO (entries 20 to 22). Each push shifts its FIFO toward the lowest index and places the new item in the highest entry. A host write in the same cycle takes priority and cancels any push.

Top module: `geo_data_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 32 entries to zero, so every index reads 0 afterwards.
- R2: Writes to indices 0, 2, 4, 6, 12, 13, 14 and 20 to 27 store the full 32-bit word. A read of the same index returns it combinationally.
- R3: A write to index 1, 3, 5, 8, 9, 10 or 11 keeps bits 15:0 and copies bit 15 into bits 31:16.
- R4: A write to index 7, 16, 17, 18 or 19 keeps bits 15:0 and clears bits 31:16.
- R5: A write to index 15 shifts the point FIFO (12 takes 13, 13 takes 14, 14 takes the written word). A read of index 15 returns entry 14.
- R6: A write to index 28 loads entries 9, 10 and 11 from bits 4:0, 9:5 and 14:10. Each 5-bit field is multiplied by 128.
- R7: A read of index 28 or 29 returns a packed word. Bits 4:0, 9:5 and 14:10 hold entries 9, 10 and 11, each divided by 128 toward zero and clamped to 0..31. Bits 31:15 are zero.
- R8: A write to index 30 stores the word. It also sets entry 31 to the count of leading bits equal to bit 31, a value from 1 to 32.
- R9: Writes to index 29 and index 31 change nothing that can be read.
- R10: A pulse on a push port shifts its FIFO toward the lowest index and loads the highest entry. The depth push zero-extends its 16-bit item.
- R11: In a cycle with a host write, all three push ports are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 5 | Host write index |
| wr_data | input | WORD_W | Host write data |
| rd_idx | input | 5 | Host read index |
| rd_data | output | WORD_W | Combinational read data |
| push_pt | input | 1 | Push strobe for the screen-point FIFO |
| push_pt_data | input | WORD_W | Point item (packed x/y) |
| push_dep | input | 1 | Push strobe for the depth FIFO |
| push_dep_data | input | HALF_W | Depth item |
| push_col | input | 1 | Push strobe for the colour FIFO |
| push_col_data | input | WORD_W | Colour item |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16-bit halves, 5-bit colour channels and a scale of 128. With these values the leading-bit count reaches its full range of 1 to 32. It covers the all-zero word, the all-one word and a lone sign bit. The defaults also let channel values land on every clamp region: negative, in range and above 31. The scoreboard reads the word back through the read port after each write or push, including after the ignored writes and the cancelled pushes.

// File: rtl/drf_pkg.sv
package drf_pkg;
    localparam int NUM_REGS = 32;
    localparam int IDX_W    = 5;
    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_VEC0_Z   = 5'd1;
    localparam idx_t IDX_VEC1_Z   = 5'd3;
    localparam idx_t IDX_VEC2_Z   = 5'd5;
    localparam idx_t IDX_ORDER    = 5'd7;
    localparam idx_t IDX_SCALE    = 5'd8;
    localparam idx_t IDX_CH1      = 5'd9;
    localparam idx_t IDX_CH2      = 5'd10;
    localparam idx_t IDX_CH3      = 5'd11;
    localparam idx_t IDX_PT0      = 5'd12;
    localparam idx_t IDX_PT1      = 5'd13;
    localparam idx_t IDX_PT2      = 5'd14;
    localparam idx_t IDX_PT_PUSH  = 5'd15;
    localparam idx_t IDX_DEP0     = 5'd16;
    localparam idx_t IDX_DEP1     = 5'd17;
    localparam idx_t IDX_DEP2     = 5'd18;
    localparam idx_t IDX_DEP3     = 5'd19;
    localparam idx_t IDX_COL0     = 5'd20;
    localparam idx_t IDX_COL1     = 5'd21;
    localparam idx_t IDX_COL2     = 5'd22;
    localparam idx_t IDX_PACK_IN  = 5'd28;
    localparam idx_t IDX_PACK_OUT = 5'd29;
    localparam idx_t IDX_LEAD_SRC = 5'd30;
    localparam idx_t IDX_LEAD_CNT = 5'd31;

    typedef enum logic [2:0] {
        WK_PLAIN,
        WK_SEXT,
        WK_ZEXT,
        WK_PT_PUSH,
        WK_PACK,
        WK_LEAD,
        WK_IGNORE
    } wkind_t;

    function automatic wkind_t classify_write(idx_t i);
        case (i)
            IDX_VEC0_Z, IDX_VEC1_Z, IDX_VEC2_Z,
            IDX_SCALE, IDX_CH1, IDX_CH2, IDX_CH3:        return WK_SEXT;
            IDX_ORDER, IDX_DEP0, IDX_DEP1,
            IDX_DEP2, IDX_DEP3:                           return WK_ZEXT;
            IDX_PT_PUSH:                                  return WK_PT_PUSH;
            IDX_PACK_IN:                                  return WK_PACK;
            IDX_LEAD_SRC:                                 return WK_LEAD;
            IDX_PACK_OUT, IDX_LEAD_CNT:                   return WK_IGNORE;
            default:                                      return WK_PLAIN;
        endcase
    endfunction
endpackage

// File: rtl/drf_write_fmt.sv
module drf_write_fmt
    import drf_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int HALF_W    = 16,
    parameter int CH_BITS   = 5,
    parameter int CH_SHIFT  = 7
) (
    input  idx_t                         idx,
    input  logic [WORD_W-1:0]            data,
    output wkind_t                       kind,
    output logic [WORD_W-1:0]            fmt_val,
    output logic [2:0][WORD_W-1:0]       ch_val
);
    localparam int PACK_W = 3 * CH_BITS;
    localparam logic [WORD_W-1:0] PACK_MASK = WORD_W'((64'd1 << PACK_W) - 64'd1);

    assign kind = classify_write(idx);

    always_comb begin
        case (kind)
            WK_SEXT: fmt_val = {{(WORD_W-HALF_W){data[HALF_W-1]}}, data[HALF_W-1:0]};
            WK_ZEXT: fmt_val = {{(WORD_W-HALF_W){1'b0}}, data[HALF_W-1:0]};
            WK_PACK: fmt_val = data & PACK_MASK;
            default: fmt_val = data;
        endcase
    end

    for (genvar g = 0; g < 3; g++) begin : g_unpack
        logic [HALF_W-1:0] scaled;
        assign scaled    = HALF_W'(data[g*CH_BITS +: CH_BITS]) << CH_SHIFT;
        assign ch_val[g] = {{(WORD_W-HALF_W){scaled[HALF_W-1]}}, scaled};
    end
endmodule

// File: rtl/drf_lead_count.sv
module drf_lead_count #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] value,
    output logic [CNT_W-1:0]  count
);
    logic [WORD_W-1:0] diff;
    assign diff = value ^ {WORD_W{value[WORD_W-1]}};

    always_comb begin
        logic found;
        found = 1'b0;
        count = CNT_W'(WORD_W);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!found && diff[i]) begin
                count = CNT_W'(WORD_W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/drf_color_pack.sv
module drf_color_pack #(
    parameter int WORD_W   = 32,
    parameter int CH_BITS  = 5,
    parameter int CH_SHIFT = 7
) (
    input  logic [2:0][WORD_W-1:0] ch_in,
    output logic [WORD_W-1:0]      packed_out
);
    localparam int PACK_W = 3 * CH_BITS;
    localparam logic [WORD_W-1:0] CH_MAX = WORD_W'((64'd1 << CH_BITS) - 64'd1);

    logic [2:0][CH_BITS-1:0] field;

    for (genvar g = 0; g < 3; g++) begin : g_chan
        logic [WORD_W-1:0] quot;
        assign quot = ch_in[g] >> CH_SHIFT;
        always_comb begin
            if (ch_in[g][WORD_W-1])   field[g] = '0;
            else if (quot > CH_MAX)   field[g] = CH_MAX[CH_BITS-1:0];
            else                      field[g] = quot[CH_BITS-1:0];
        end
    end

    assign packed_out = {{(WORD_W-PACK_W){1'b0}}, field[2], field[1], field[0]};
endmodule

// File: rtl/geo_data_regfile.sv
module geo_data_regfile
    import drf_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_W   = 16,
    parameter int CH_BITS  = 5,
    parameter int CH_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [4:0]        rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              push_pt,
    input  logic [WORD_W-1:0] push_pt_data,
    input  logic              push_dep,
    input  logic [HALF_W-1:0] push_dep_data,
    input  logic              push_col,
    input  logic [WORD_W-1:0] push_col_data
);
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int PACK_W = 3 * CH_BITS;

    logic [WORD_W-1:0]       regs_q [NUM_REGS];
    wkind_t                  wkind;
    logic [WORD_W-1:0]       fmt_val;
    logic [2:0][WORD_W-1:0]  unpack_val;
    logic [CNT_W-1:0]        lead_cnt;
    logic [2:0][WORD_W-1:0]  ch_cur;
    logic [WORD_W-1:0]       pack_rd;

    drf_write_fmt #(
        .WORD_W(WORD_W), .HALF_W(HALF_W), .CH_BITS(CH_BITS), .CH_SHIFT(CH_SHIFT)
    ) u_fmt (
        .idx(wr_idx), .data(wr_data), .kind(wkind), .fmt_val(fmt_val), .ch_val(unpack_val)
    );

    drf_lead_count #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lead (
        .value(wr_data), .count(lead_cnt)
    );

    assign ch_cur[0] = regs_q[IDX_CH1];
    assign ch_cur[1] = regs_q[IDX_CH2];
    assign ch_cur[2] = regs_q[IDX_CH3];

    drf_color_pack #(.WORD_W(WORD_W), .CH_BITS(CH_BITS), .CH_SHIFT(CH_SHIFT)) u_pack (
        .ch_in(ch_cur), .packed_out(pack_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            case (wkind)
                WK_PLAIN, WK_SEXT, WK_ZEXT: regs_q[wr_idx] <= fmt_val;
                WK_PT_PUSH: begin
                    regs_q[IDX_PT0] <= regs_q[IDX_PT1];
                    regs_q[IDX_PT1] <= regs_q[IDX_PT2];
                    regs_q[IDX_PT2] <= wr_data;
                end
                WK_PACK: begin
                    regs_q[IDX_PACK_IN] <= fmt_val;
                    regs_q[IDX_CH1]     <= unpack_val[0];
                    regs_q[IDX_CH2]     <= unpack_val[1];
                    regs_q[IDX_CH3]     <= unpack_val[2];
                end
                WK_LEAD: begin
                    regs_q[IDX_LEAD_SRC] <= wr_data;
                    regs_q[IDX_LEAD_CNT] <= WORD_W'(lead_cnt);
                end
                default: ;
            endcase
        end else begin
            if (push_pt) begin
                regs_q[IDX_PT0] <= regs_q[IDX_PT1];
                regs_q[IDX_PT1] <= regs_q[IDX_PT2];
                regs_q[IDX_PT2] <= push_pt_data;
            end
            if (push_dep) begin
                regs_q[IDX_DEP0] <= regs_q[IDX_DEP1];
                regs_q[IDX_DEP1] <= regs_q[IDX_DEP2];
                regs_q[IDX_DEP2] <= regs_q[IDX_DEP3];
                regs_q[IDX_DEP3] <= {{(WORD_W-HALF_W){1'b0}}, push_dep_data};
            end
            if (push_col) begin
                regs_q[IDX_COL0] <= regs_q[IDX_COL1];
                regs_q[IDX_COL1] <= regs_q[IDX_COL2];
                regs_q[IDX_COL2] <= push_col_data;
            end
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_PT_PUSH:               rd_data = regs_q[IDX_PT2];
            IDX_PACK_IN, IDX_PACK_OUT: rd_data = pack_rd;
            default:                   rd_data = regs_q[rd_idx];
        endcase
    end

    logic [WORD_W-1:0] pt0_q, pt1_q, pt2_q, dep0_q, dep1_q, dep3_q, lead_q;
    assign pt0_q  = regs_q[IDX_PT0];
    assign pt1_q  = regs_q[IDX_PT1];
    assign pt2_q  = regs_q[IDX_PT2];
    assign dep0_q = regs_q[IDX_DEP0];
    assign dep1_q = regs_q[IDX_DEP1];
    assign dep3_q = regs_q[IDX_DEP3];
    assign lead_q = regs_q[IDX_LEAD_CNT];

    AST_PT_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_PT_PUSH) |=> (pt0_q == $past(pt1_q) && pt2_q == $past(wr_data))); // R5
    AST_LEAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_LEAD_SRC) |=> (lead_q >= 1 && lead_q <= WORD_W)); // R8
    AST_RO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_LEAD_CNT) |=> $stable(lead_q)); // R9
    AST_PACK_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_PACK_IN || rd_idx == IDX_PACK_OUT) |-> (rd_data[WORD_W-1:PACK_W] == '0)); // R7
    AST_DEP_PUSH: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && push_dep) |=> (dep0_q == $past(dep1_q)
            && dep3_q == {{(WORD_W-HALF_W){1'b0}}, $past(push_dep_data)})); // R10
    AST_PUSH_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && push_pt && wr_idx != IDX_PT0 && wr_idx != IDX_PT1
            && wr_idx != IDX_PT2 && wr_idx != IDX_PT_PUSH) |=> $stable(pt2_q)); // R11
endmodule

// File: tb/geo_data_regfile_bench.sv
module geo_data_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        push_pt = 1'b0, push_dep = 1'b0, push_col = 1'b0;
    logic [31:0] push_pt_data = '0, push_col_data = '0;
    logic [15:0] push_dep_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] q_val [$];
    logic [4:0]  q_idx [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    geo_data_regfile u_geo_data_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .push_pt(push_pt), .push_pt_data(push_pt_data),
        .push_dep(push_dep), .push_dep_data(push_dep_data),
        .push_col(push_col), .push_col_data(push_col_data)
    );

    // monitor: pops expectations and compares against the read port
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_val.size() > 0) begin
                logic [31:0] ev;
                logic [4:0]  ei;
                string       et;
                ev = q_val.pop_front();
                ei = q_idx.pop_front();
                et = q_tag.pop_front();
                n_tests++;
                if (rd_data !== ev) begin
                    n_fail++;
                    $display("FAIL %s idx=%0d actual=0x%08h expected=0x%08h", et, ei, rd_data, ev);
                end
            end
        end
    end

    task automatic chk(input logic [4:0] i, input logic [31:0] ev, input string tag);
        @(negedge clk);
        rd_idx = i;
        q_idx.push_back(i);
        q_val.push_back(ev);
        q_tag.push_back(tag);
    endtask

    task automatic wr(input logic [4:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input bit p, input bit dz, input bit c,
                        input logic [31:0] xy, input logic [15:0] z, input logic [31:0] col,
                        input bit with_wr, input logic [4:0] wi, input logic [31:0] wd);
        @(negedge clk);
        push_pt = p; push_dep = dz; push_col = c;
        push_pt_data = xy; push_dep_data = z; push_col_data = col;
        wr_en = with_wr; wr_idx = wi; wr_data = wd;
        @(negedge clk);
        push_pt = 1'b0; push_dep = 1'b0; push_col = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(5'd0,  32'h0, "R1");
        chk(5'd31, 32'h0, "R1");
        chk(5'd28, 32'h0, "R1");
        wr(5'd2, 32'h0000_0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(5'd2, 32'h0, "R1 mid-run reset");

        // R2: plain storage
        wr(5'd0, 32'h1234_5678);  chk(5'd0, 32'h1234_5678, "R2");
        wr(5'd24, 32'h8000_0001); chk(5'd24, 32'h8000_0001, "R2");

        // R3: sign extension
        wr(5'd1, 32'hABCD_8001);  chk(5'd1, 32'hFFFF_8001, "R3");
        wr(5'd8, 32'h0001_7FFF);  chk(5'd8, 32'h0000_7FFF, "R3");

        // R4: zero extension
        wr(5'd7, 32'hFFFF_9ABC);  chk(5'd7, 32'h0000_9ABC, "R4");
        wr(5'd18, 32'h1234_F000); chk(5'd18, 32'h0000_F000, "R4");

        // R5: point FIFO push slot and mirror read
        wr(5'd12, 32'hA0A0_0001);
        wr(5'd13, 32'hB0B0_0002);
        wr(5'd14, 32'hC0C0_0003);
        wr(5'd15, 32'hD0D0_0004);
        chk(5'd12, 32'hB0B0_0002, "R5");
        chk(5'd13, 32'hC0C0_0003, "R5");
        chk(5'd14, 32'hD0D0_0004, "R5");
        chk(5'd15, 32'hD0D0_0004, "R5");

        // R6: packed colour write loads channels (fields 1, 31, 16)
        wr(5'd28, 32'hFFFF_43E1);
        chk(5'd9,  32'h0000_0080, "R6");
        chk(5'd10, 32'h0000_0F80, "R6");
        chk(5'd11, 32'h0000_0800, "R6");
        chk(5'd28, 32'h0000_43E1, "R7 round trip");

        // R7: clamp cases: -127 -> 0, 0x7FFF -> 31, 383 -> 2
        wr(5'd9,  32'h0000_FF81);
        wr(5'd10, 32'h0000_7FFF);
        wr(5'd11, 32'h0000_017F);
        chk(5'd28, 32'h0000_0BE0, "R7");
        chk(5'd29, 32'h0000_0BE0, "R7");
        wr(5'd9, 32'h0000_8000);
        wr(5'd11, 32'h0000_0FFF);
        chk(5'd28, 32'h0000_7FE0, "R7 clamp");

        // R8: leading-bit count
        wr(5'd30, 32'h0000_0000); chk(5'd31, 32'd32, "R8"); chk(5'd30, 32'h0, "R8");
        wr(5'd30, 32'hFFFF_FFFF); chk(5'd31, 32'd32, "R8");
        wr(5'd30, 32'h8000_0000); chk(5'd31, 32'd1,  "R8");
        wr(5'd30, 32'h0000_FFFF); chk(5'd31, 32'd16, "R8");
        wr(5'd30, 32'hFFF0_0000); chk(5'd31, 32'd12, "R8");
        chk(5'd30, 32'hFFF0_0000, "R8");

        // R9: ignored writes
        wr(5'd31, 32'h0000_0055); chk(5'd31, 32'd12, "R9");
        wr(5'd29, 32'h0000_FFFF); chk(5'd29, 32'h0000_7FE0, "R9");

        // R10: internal pushes, all three in one cycle
        wr(5'd16, 32'd1); wr(5'd17, 32'd2); wr(5'd18, 32'd3); wr(5'd19, 32'd4);
        wr(5'd20, 32'h100); wr(5'd21, 32'h200); wr(5'd22, 32'h300);
        push(1'b1, 1'b1, 1'b1, 32'h1111_2222, 16'hBEEF, 32'h0A0B_0C0D, 1'b0, 5'd0, 32'h0);
        chk(5'd12, 32'hC0C0_0003, "R10");
        chk(5'd14, 32'h1111_2222, "R10");
        chk(5'd16, 32'd2, "R10");
        chk(5'd19, 32'h0000_BEEF, "R10");
        chk(5'd20, 32'h200, "R10");
        chk(5'd22, 32'h0A0B_0C0D, "R10");

        // R11: host write cancels same-cycle pushes
        push(1'b1, 1'b1, 1'b1, 32'h9999_9999, 16'h1234, 32'h5555_5555, 1'b1, 5'd0, 32'h77);
        chk(5'd0,  32'h77, "R11");
        chk(5'd14, 32'h1111_2222, "R11");
        chk(5'd19, 32'h0000_BEEF, "R11");
        chk(5'd22, 32'h0A0B_0C0D, "R11");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule